// File: doc/BRIEF.md
# Energy-Detect Power-Down Controller

This controller puts a line-interface block into a low-power state whenever the line carries no energy, and brings it back when energy returns. An arming bit turns the feature on; with it clear the block never powers down. While armed and idle, `pwr_down_o` gates the transmit and receive paths. The management interface, squelch and energy detector are not driven by `pwr_down_o` and stay powered. The energy-detect input is asynchronous and comes from the analog detector.

The energy input passes a two-flop synchronizer and a debounce filter. A registered state machine then moves between active, powered-down and settling. On entry to power-down it captures the block's operating-state word. On wake it presents that word again, with a one-cycle restore pulse, so the gated logic can reload it. Receive and transmit stay qualified off until a settle interval has elapsed. This lets the packets that caused the wake be discarded instead of being passed on corrupted.

Every wake caused by energy sets a sticky event flag. The host clears the flag with a write-one-to-clear strobe. The host interrupt is the flag masked by an enable.

Top module: `edpd_ctrl`

## Requirements
- R1: With `mode_en_i` low, `pwr_down_o` never asserts, whatever `energy_i` does. Clearing `mode_en_i` while powered down leaves power-down on the next clock edge, with a restore pulse and without setting the event flag.
- R2: With `mode_en_i` high and the filtered energy low, `pwr_down_o` is high, `ready_o` is low and `tx_en_o` is low.
- R3: `energy_i` goes through two synchronizer flops and must hold a new level for `DEB_CYC` consecutive cycles before it counts. A level held for fewer cycles has no effect. A held change shows on `pwr_down_o` at the `DEB_CYC+3`-th clock edge after the input changes.
- R4: On wake, `pwr_down_o` falls and `restore_o` is high for exactly one cycle. In that cycle `op_state_o` carries the operating-state word captured when power-down began.
- R5: From entry to power-down until `ready_o` rises, `op_state_o` holds the captured word and ignores `op_state_i`. While ready, it follows `op_state_i`.
- R6: After a wake, `ready_o` stays low for `SETTLE_CYC` cycles. `rx_vld_o` equals `rx_vld_i` AND `ready_o`, and `tx_en_o` equals `tx_req_i` AND `ready_o`.
- R7: A wake caused by energy sets `irq_flag_o`. The flag stays set until a cycle with `flag_clr_i` high clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq_o` is `irq_flag_o` AND `irq_en_i`, with no added cycle.
- R9: After reset the block is active: `ready_o` high, `pwr_down_o` low, `irq_flag_o` low, `restore_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en_i | input | 1 | Arms energy-detect power-down |
| energy_i | input | 1 | Asynchronous line-energy indication |
| irq_en_i | input | 1 | Host interrupt enable for the wake event |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the event flag |
| op_state_i | input | STATE_W | Live operating-state word of the line block |
| tx_req_i | input | 1 | Transmit request from the line block |
| rx_vld_i | input | 1 | Raw receive-data valid |
| pwr_down_o | output | 1 | Gates transmit and receive logic |
| ready_o | output | 1 | Powered up and settled |
| tx_en_o | output | 1 | Qualified transmit enable |
| rx_vld_o | output | 1 | Qualified receive valid |
| op_state_o | output | STATE_W | Operating-state word (held copy while down or settling) |
| restore_o | output | 1 | One-cycle pulse to reload the held state |
| irq_flag_o | output | 1 | Sticky wake-event flag |
| irq_o | output | 1 | Host interrupt |

## Verification
A held energy edge reaches the state register at the `DEB_CYC+3`-th rising edge. The flag and the restore pulse appear on that same edge, and `ready_o` follows `SETTLE_CYC` edges later. `irq_o`, `tx_en_o` and `rx_vld_o` are combinational on top of registered state and follow their inputs in the same cycle. The bench drives inputs on falling edges and counts rising edges from the drive. It samples one edge before and exactly at each expected change, so a latency off by one cycle is seen. The glitch test holds energy for fewer cycles than the filter needs and then samples well past the point where a wake would have shown.

// File: rtl/edpd_pkg.sv
package edpd_pkg;
    typedef enum logic [1:0] {
        PS_ACTIVE = 2'd0,
        PS_DOWN   = 2'd1,
        PS_SETTLE = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/edpd_sync_filter.sv
module edpd_sync_filter #(
    parameter int DEB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t d, q;

    always_comb begin
        d    = q;
        d.s1 = raw_i;
        d.s2 = q.s1;
        if (q.s2 != q.filt) begin
            if (q.cnt == CW'(DEB_CYC - 1)) begin
                d.filt = q.s2;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign filt_o = q.filt;

    // R3
    filt_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_o) |-> (filt_o == $past(q.s2)));
endmodule

// File: rtl/edpd_pwr_fsm.sv
module edpd_pwr_fsm
    import edpd_pkg::*;
#(
    parameter int SETTLE_CYC = 64,
    parameter int STATE_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_en_i,
    input  logic               energy_i,
    input  logic [STATE_W-1:0] op_state_i,
    output logic               pwr_down_o,
    output logic               ready_o,
    output logic               restore_o,
    output logic               wake_evt_o,
    output logic [STATE_W-1:0] saved_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        pwr_state_e         st;
        logic [CW-1:0]      cnt;
        logic [STATE_W-1:0] saved;
        logic               restore;
    } fsm_t;

    fsm_t d, q;
    logic wake_evt;

    always_comb begin
        d         = q;
        d.restore = 1'b0;
        wake_evt  = 1'b0;
        unique case (q.st)
            PS_ACTIVE: begin
                if (mode_en_i && !energy_i) begin
                    d.st    = PS_DOWN;
                    d.saved = op_state_i;
                end
            end
            PS_DOWN: begin
                if (!mode_en_i || energy_i) begin
                    d.st      = PS_SETTLE;
                    d.cnt     = '0;
                    d.restore = 1'b1;
                    wake_evt  = energy_i;
                end
            end
            PS_SETTLE: begin
                if (mode_en_i && !energy_i) begin
                    d.st = PS_DOWN;
                end else if (q.cnt == CW'(SETTLE_CYC - 1)) begin
                    d.st = PS_ACTIVE;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.st = PS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= PS_ACTIVE;
            q.cnt     <= '0;
            q.saved   <= '0;
            q.restore <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pwr_down_o = (q.st == PS_DOWN);
    assign ready_o    = (q.st == PS_ACTIVE);
    assign restore_o  = q.restore;
    assign wake_evt_o = wake_evt;
    assign saved_o    = q.saved;

    // R1
    down_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_o |-> $past(mode_en_i));

    // R4
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down_o) |-> ($past(energy_i) || !$past(mode_en_i)));

    // R4
    restore_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |=> !restore_o);

    // R6
    ready_via_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(q.st) == PS_SETTLE));
endmodule

// File: rtl/edpd_irq_flag.sv
module edpd_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_evt_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
    } irq_t;

    irq_t d, q;

    always_comb begin
        d = q;
        if (wake_evt_i)  d.flag = 1'b1;
        else if (clr_i)  d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag_o = q.flag;
    assign irq_o  = q.flag & irq_en_i;

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt_i |=> flag_o);

    // R7
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(wake_evt_i));

    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/edpd_ctrl.sv
module edpd_ctrl #(
    parameter int DEB_CYC    = 16,
    parameter int SETTLE_CYC = 64,
    parameter int STATE_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_en_i,
    input  logic               energy_i,
    input  logic               irq_en_i,
    input  logic               flag_clr_i,
    input  logic [STATE_W-1:0] op_state_i,
    input  logic               tx_req_i,
    input  logic               rx_vld_i,
    output logic               pwr_down_o,
    output logic               ready_o,
    output logic               tx_en_o,
    output logic               rx_vld_o,
    output logic [STATE_W-1:0] op_state_o,
    output logic               restore_o,
    output logic               irq_flag_o,
    output logic               irq_o
);
    logic               energy_filt;
    logic               wake_evt;
    logic [STATE_W-1:0] saved_state;

    edpd_sync_filter #(.DEB_CYC(DEB_CYC)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (energy_i),
        .filt_o (energy_filt)
    );

    edpd_pwr_fsm #(.SETTLE_CYC(SETTLE_CYC), .STATE_W(STATE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en_i  (mode_en_i),
        .energy_i   (energy_filt),
        .op_state_i (op_state_i),
        .pwr_down_o (pwr_down_o),
        .ready_o    (ready_o),
        .restore_o  (restore_o),
        .wake_evt_o (wake_evt),
        .saved_o    (saved_state)
    );

    edpd_irq_flag u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_evt_i (wake_evt),
        .clr_i      (flag_clr_i),
        .irq_en_i   (irq_en_i),
        .flag_o     (irq_flag_o),
        .irq_o      (irq_o)
    );

    assign tx_en_o    = tx_req_i & ready_o;
    assign rx_vld_o   = rx_vld_i & ready_o;
    assign op_state_o = ready_o ? op_state_i : saved_state;

    // R6
    rx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_o |-> (!rx_vld_o && !tx_en_o));
endmodule

// File: tb/edpd_ctrl_bench.sv
`timescale 1ns/1ps
module edpd_ctrl_bench;
    localparam int DEB  = 4;
    localparam int SETL = 8;
    localparam int SW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0, energy = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
    logic tx_req = 1'b0, rx_vld = 1'b0;
    logic [SW-1:0] op_in = '0;
    logic pwr_down, ready, tx_en, rx_vld_q, restore, flag, irq;
    logic [SW-1:0] op_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    edpd_ctrl #(.DEB_CYC(DEB), .SETTLE_CYC(SETL), .STATE_W(SW)) u_edpd_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_en_i(mode_en), .energy_i(energy),
        .irq_en_i(irq_en), .flag_clr_i(flag_clr), .op_state_i(op_in),
        .tx_req_i(tx_req), .rx_vld_i(rx_vld), .pwr_down_o(pwr_down),
        .ready_o(ready), .tx_en_o(tx_en), .rx_vld_o(rx_vld_q),
        .op_state_o(op_out), .restore_o(restore), .irq_flag_o(flag), .irq_o(irq)
    );

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R9 ready", 32'(ready), 1);
        chk("R9 pwr_down", 32'(pwr_down), 0);
        chk("R9 flag", 32'(flag), 0);
        chk("R9 restore", 32'(restore), 0);
        tx_req = 1'b1;
        #1 chk("R6 tx pass when ready", 32'(tx_en), 1);
    endtask

    task automatic t_disabled();
        edges(20);
        chk("R1 no power-down while disabled", 32'(pwr_down), 0);
        chk("R1 ready while disabled", 32'(ready), 1);
    endtask

    task automatic t_enter_down();
        mode_en = 1'b1;
        op_in   = 8'hA5;
        #1 chk("R2 not before edge", 32'(pwr_down), 0);
        edges(1);
        chk("R2 pwr_down", 32'(pwr_down), 1);
        chk("R2 ready low", 32'(ready), 0);
        chk("R2 tx blocked", 32'(tx_en), 0);
        chk("R5 captured state", 32'(op_out), 32'hA5);
        op_in = 8'h3C;
        edges(2);
        chk("R5 held while down", 32'(op_out), 32'hA5);
    endtask

    task automatic t_glitch();
        energy = 1'b1;
        edges(2);
        energy = 1'b0;
        edges(12);
        chk("R3 short pulse ignored", 32'(pwr_down), 1);
        chk("R3 no flag on glitch", 32'(flag), 0);
    endtask

    task automatic t_wake();
        energy = 1'b1;
        edges(DEB + 2);
        chk("R3 still down one edge early", 32'(pwr_down), 1);
        edges(1);
        chk("R4 woke", 32'(pwr_down), 0);
        chk("R4 restore pulse", 32'(restore), 1);
        chk("R4 restored word", 32'(op_out), 32'hA5);
        chk("R7 flag set", 32'(flag), 1);
        chk("R8 masked irq", 32'(irq), 0);
        rx_vld = 1'b1;
        edges(1);
        chk("R4 restore single cycle", 32'(restore), 0);
        chk("R6 rx gated while settling", 32'(rx_vld_q), 0);
        chk("R5 held while settling", 32'(op_out), 32'hA5);
        edges(SETL - 2);
        chk("R6 not ready one edge early", 32'(ready), 0);
        edges(1);
        chk("R6 ready after settle", 32'(ready), 1);
        chk("R6 rx passes", 32'(rx_vld_q), 1);
        chk("R5 live state", 32'(op_out), 32'h3C);
        edges(20);
        chk("R7 flag sticky", 32'(flag), 1);
    endtask

    task automatic t_irq();
        irq_en = 1'b1;
        #1 chk("R8 irq follows enable", 32'(irq), 1);
        @(negedge clk);
        flag_clr = 1'b1;
        edges(1);
        flag_clr = 1'b0;
        chk("R7 flag cleared", 32'(flag), 0);
        chk("R8 irq dropped", 32'(irq), 0);
    endtask

    task automatic t_collision();
        energy = 1'b0;
        edges(DEB + 2);
        chk("R3 still up one edge early", 32'(pwr_down), 0);
        edges(1);
        chk("R3 down after filter", 32'(pwr_down), 1);
        energy = 1'b1;
        edges(DEB + 2);
        flag_clr = 1'b1;
        edges(1);
        flag_clr = 1'b0;
        chk("R7 set wins over clear", 32'(flag), 1);
        chk("R4 woke again", 32'(pwr_down), 0);
        edges(SETL + 2);
        flag_clr = 1'b1;
        edges(1);
        flag_clr = 1'b0;
        chk("R7 cleared after collision", 32'(flag), 0);
    endtask

    task automatic t_disable_in_down();
        energy = 1'b0;
        edges(DEB + 3);
        chk("R2 down again", 32'(pwr_down), 1);
        mode_en = 1'b0;
        edges(1);
        chk("R1 disable leaves down", 32'(pwr_down), 0);
        chk("R1 restore on disable", 32'(restore), 1);
        chk("R1 no flag on disable", 32'(flag), 0);
        chk("R8 no irq on disable", 32'(irq), 0);
        edges(SETL);
        chk("R1 ready after disable", 32'(ready), 1);
        edges(10);
        chk("R1 stays up with no energy", 32'(pwr_down), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_enter_down();
        t_glitch();
        t_wake();
        t_irq();
        t_collision();
        t_disable_in_down();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule